// File: doc/BRIEF.md
# I2C Register-Access Target Port

This block is an I2C target that lets an external bus master read and write a bank of byte-wide control registers. The registers are reached through a register pointer that is `PTR_BYTES` bytes wide. The bus lines reach the block as plain input levels. The block samples them with its own system clock, which runs much faster than the bus clock. Its only influence on the bus is a single SDA pull-low enable. Register storage is outside the block. The block offers a simple strobe interface to it: an address, write data with a one-cycle write strobe, and read data that is sampled on a one-cycle read strobe.

A write transfer starts with the device address byte with the direction bit clear. The pointer bytes follow, most significant byte first. Every byte after that is written to the register at the pointer, and the pointer then advances. A read transfer starts with the device address byte with the direction bit set. The block then sends register bytes starting at the current pointer, for as long as the master acknowledges them. To set up a read at a chosen address, the master sends a write that carries only the pointer bytes, then a repeated start and a read. A start or stop condition may arrive at any point. Any byte that is only partly received is then dropped.

Top module: `i2c_reg_target`

## Requirements
- R1: The first byte after a start holds a 7-bit device address in bits 7..1, sent MSB first, and a direction bit in bit 0 (0 = write, 1 = read). Only when the address equals `DEV_ADDR` does the block pull SDA low during the ninth pulse. For any other address the block never pulls SDA and gives no strobe until the next start.
- R2: In a write transfer, the `PTR_BYTES` bytes after the address byte load the register pointer, most significant byte first. Each of these bytes is acknowledged.
- R3: In a write transfer, every byte after the pointer bytes gives one cycle of `reg_we_o`, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. Each such byte is acknowledged, and a transfer may hold any number of them.
- R4: The pointer goes up by one after each byte written or read, and wraps from its largest value (65535 by default) to 0.
- R5: In a read transfer, each byte is fetched with one cycle of `reg_re_o` at the current pointer and is shifted out MSB first. The first byte comes from the pointer left by the previous transfer, including a transfer that carried only pointer bytes.
- R6: The block sends another byte after each byte the master acknowledges. When the master leaves SDA high on the ninth pulse, the block releases SDA and fetches nothing more until the next start.
- R7: A repeated start in place of a stop takes the block straight back to receiving an address byte.
- R8: A start or stop condition in the middle of a byte discards the partial byte. It causes no register write and leaves the pointer unchanged.
- R9: The block begins pulling SDA only while SCL is low. It releases its drive on the SCL falling edge that ends each acknowledge or data bit, and at every start or stop condition.
- R10: After reset, `sda_pull_o`, `reg_we_o` and `reg_re_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| reg_addr_o | output | 8*PTR_BYTES | Register pointer presented to the register bank |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register byte, sampled while `reg_re_o` is high |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h4B, `PTR_BYTES` = 2 and `SYNC_STAGES` = 2. With the full 16-bit pointer, the wrap from 65535 to 0 can be reached by one short burst at pointer 16'hFFFE. The bench drives each quarter of a bus bit for six system clocks. This is longer than the three-clock delay of synchronising and edge-detecting the lines, so acknowledge timing and the release of SDA on falling edges are tested in a realistic way. Random write and read bursts at random pointers are mixed with directed cases. The directed cases are a wrong address, a repeated start, a partial byte ended by a stop, and a partial byte ended by a start.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  // Protocol phase of the target
  typedef enum logic [2:0] {
    PH_IDLE,   // off the bus, waiting for a start
    PH_RX,     // shifting in a byte from the master
    PH_RXACK,  // driving the acknowledge for a received byte
    PH_TX,     // shifting out a register byte
    PH_TXACK   // listening to the master's acknowledge
  } phase_e;

  // Meaning of the byte currently being received
  typedef enum logic [1:0] {
    BY_DEV,
    BY_PTR,
    BY_DATA
  } byte_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prv_o
);

  // One chain per line; the last stage holds the previous level for edges.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    assign chain_d = {chain_q[STAGES-1:0], raw_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign lvl_o[i] = chain_q[STAGES-1];
    assign prv_o[i] = chain_q[STAGES];
  end

endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
  input  logic scl_lvl,
  input  logic scl_prv,
  input  logic sda_lvl,
  input  logic sda_prv,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_held_high;

  assign scl_held_high = scl_lvl & scl_prv;
  assign scl_rise      = scl_lvl & ~scl_prv;
  assign scl_fall      = ~scl_lvl & scl_prv;
  assign start_ev      = scl_held_high & sda_prv & ~sda_lvl;
  assign stop_ev       = scl_held_high & ~sda_prv & sda_lvl;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h4B,
  parameter int         PTR_BYTES = 2,
  localparam int        PTR_W     = BYTE_W * PTR_BYTES,
  localparam int        PIDX_W    = $clog2(PTR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_pull,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);

  phase_e              phase_q, phase_d;
  byte_e               kind_q,  kind_d;
  logic [3:0]          bit_q,   bit_d;
  logic [BYTE_W-1:0]   sh_q,    sh_d;
  logic [PTR_W-1:0]    ptr_q,   ptr_d;
  logic [PIDX_W-1:0]   pidx_q,  pidx_d;
  logic                pull_q,  pull_d;
  logic                rw_q,    rw_d;
  logic                mack_q,  mack_d;
  logic                load_rd;
  logic [PTR_W-1:0]    ptr_shift;
  logic [PTR_W-1:0]    ptr_inc;

  // Pointer bytes enter at the bottom so the first byte ends up on top.
  if (PTR_BYTES > 1) begin : g_ptr_wide
    assign ptr_shift = {ptr_q[PTR_W-BYTE_W-1:0], sh_q};
  end else begin : g_ptr_narrow
    assign ptr_shift = sh_q;
  end

  assign ptr_inc = ptr_q + PTR_W'(1);

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    pidx_d  = pidx_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    reg_we  = 1'b0;
    reg_re  = 1'b0;
    load_rd = 1'b0;

    if (stop_ev) begin
      phase_d = PH_IDLE;
      pull_d  = 1'b0;
    end else if (start_ev) begin
      // Start or repeated start: any partial byte is simply forgotten.
      phase_d = PH_RX;
      kind_d  = BY_DEV;
      bit_d   = '0;
      pidx_d  = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            unique case (kind_q)
              BY_DEV: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_d    = sh_q[0];
                  pull_d  = 1'b1;
                  phase_d = PH_RXACK;
                end else begin
                  phase_d = PH_IDLE;
                end
              end
              BY_PTR: begin
                ptr_d   = ptr_shift;
                pidx_d  = pidx_q + PIDX_W'(1);
                pull_d  = 1'b1;
                phase_d = PH_RXACK;
              end
              default: begin
                reg_we  = 1'b1;
                ptr_d   = ptr_inc;
                pull_d  = 1'b1;
                phase_d = PH_RXACK;
              end
            endcase
          end
        end

        PH_RXACK: begin
          if (scl_fall) begin
            if (kind_q == BY_DEV && rw_q) begin
              load_rd = 1'b1;
            end else begin
              pull_d  = 1'b0;
              phase_d = PH_RX;
              bit_d   = '0;
              if (kind_q == BY_DEV) begin
                kind_d = (PTR_BYTES > 0) ? BY_PTR : BY_DATA;
              end else if (kind_q == BY_PTR && pidx_q == PIDX_W'(PTR_BYTES)) begin
                kind_d = BY_DATA;
              end
            end
          end
        end

        PH_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              pull_d  = 1'b0;
              phase_d = PH_TXACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              bit_d  = bit_q + 4'd1;
              pull_d = ~sh_q[BYTE_W-2];
            end
          end
        end

        PH_TXACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) load_rd = 1'b1;
            else        phase_d = PH_IDLE;
          end
        end

        default: ;
      endcase
    end

    // Fetch of the next register byte for a read
    if (load_rd) begin
      reg_re  = 1'b1;
      sh_d    = reg_rdata;
      ptr_d   = ptr_inc;
      pull_d  = ~reg_rdata[BYTE_W-1];
      bit_d   = '0;
      phase_d = PH_TX;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= BY_DEV;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      pidx_q  <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      pidx_q  <= pidx_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_pull  = pull_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4B,
  parameter int         PTR_BYTES   = 2,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = BYTE_W * PTR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic [1:0] line_lvl;
  logic [1:0] line_prv;
  logic       scl_lvl;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  i2c_tgt_sync #(
    .LINES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw_i ({scl_i, sda_i}),
    .lvl_o (line_lvl),
    .prv_o (line_prv)
  );

  assign scl_lvl = line_lvl[1];

  i2c_tgt_events u_events (
    .scl_lvl  (line_lvl[1]),
    .scl_prv  (line_prv[1]),
    .sda_lvl  (line_lvl[0]),
    .sda_prv  (line_prv[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR  (DEV_ADDR),
    .PTR_BYTES (PTR_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_lvl   (line_lvl[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_pull  (sda_pull_o),
    .reg_addr  (reg_addr_o),
    .reg_wdata (reg_wdata_o),
    .reg_we    (reg_we_o),
    .reg_re    (reg_re_o),
    .reg_rdata (reg_rdata_i)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             sda_pull_o,
  input logic             reg_we_o,
  input logic             reg_re_o,
  input logic [PTR_W-1:0] reg_addr_o
);

  // R9: a new pull-low drive appears only while the sampled SCL is low
  assert_pull_on_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl);

  // R9 / R7: a start or stop releases SDA on the next cycle
  assert_release_on_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_pull_o);

  // R4: a write advances the pointer by one
  assert_ptr_step_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + PTR_W'(1)));

  // R4: a read fetch advances the pointer by one
  assert_ptr_step_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> (reg_addr_o == $past(reg_addr_o) + PTR_W'(1)));

  // R3 / R5: write and read strobes never coincide
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we_o, reg_re_o}));

  // R8: a condition never coincides with a write strobe
  assert_no_write_on_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> !reg_we_o);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(
  .PTR_W (PTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .scl_lvl    (scl_lvl),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .sda_pull_o (sda_pull_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;

  localparam int         Q   = 6;
  localparam logic [6:0] DEV = 7'h4B;

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_line;
  logic        sda_pull;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [7:0]  reg_rdata;

  int total = 0;
  int bad   = 0;
  int re_cnt = 0;
  int viol   = 0;
  logic [23:0] wlog [$];
  logic [15:0] exp_ptr;
  logic        pull_prev;

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign sda_line  = sda_m & ~sda_pull;
  assign reg_rdata = rd_fn(reg_addr);

  i2c_reg_target #(
    .DEV_ADDR    (DEV),
    .PTR_BYTES   (2),
    .SYNC_STAGES (2)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Strobe capture and drive-while-SCL-high monitor
  always @(posedge clk) begin
    if (reg_we) wlog.push_back({reg_addr, reg_wdata});
    if (reg_re) re_cnt++;
    if (rst_n && sda_pull != pull_prev && scl_m) viol++;
    pull_prev <= sda_pull;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    waitq();
    sda_m = b;
    waitq();
    scl_m = 1'b1;
    waitq();
    s = sda_line;
    waitq();
    scl_m = 1'b0;
  endtask

  task automatic cond_start();
    if (!scl_m) begin
      waitq();
      sda_m = 1'b1;
      waitq();
      scl_m = 1'b1;
    end
    waitq();
    sda_m = 1'b0;
    waitq();
    scl_m = 1'b0;
  endtask

  task automatic cond_stop();
    waitq();
    sda_m = 1'b0;
    waitq();
    scl_m = 1'b1;
    waitq();
    sda_m = 1'b1;
    waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bus_bit(b[i], s);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    bus_bit(~mack, s);
  endtask

  // Address and pointer phase of a write, acks checked
  task automatic wr_head(input logic [15:0] p);
    logic ack;
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R1", "write address ack", ack, 1);
    send_byte(p[15:8], ack);
    chk(ack, "R2", "pointer high ack", ack, 1);
    send_byte(p[7:0], ack);
    chk(ack, "R2", "pointer low ack", ack, 1);
    exp_ptr = p;
  endtask

  task automatic wr_txn(input logic [15:0] p, input int n);
    logic       ack;
    logic [7:0] d [8];
    logic [15:0] a;
    wlog.delete();
    cond_start();
    wr_head(p);
    for (int i = 0; i < n; i++) begin
      d[i] = 8'($urandom);
      send_byte(d[i], ack);
      chk(ack, "R3", "data byte ack", ack, 1);
    end
    cond_stop();
    chk(wlog.size() == n, "R3", "write strobe count", wlog.size(), n);
    for (int i = 0; i < n && i < wlog.size(); i++) begin
      a = p + 16'(i);
      chk(wlog[i][23:8] == a, "R4", "write address", int'(wlog[i][23:8]), int'(a));
      chk(wlog[i][7:0] == d[i], "R3", "write data", int'(wlog[i][7:0]), int'(d[i]));
    end
    exp_ptr = p + 16'(n);
  endtask

  // Read body after a start: address, n bytes, NACK on the last
  task automatic rd_body(input int n);
    logic       ack;
    logic [7:0] d;
    int         r0;
    r0 = re_cnt;
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R1", "read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == rd_fn(exp_ptr), "R5", "read data", d, rd_fn(exp_ptr));
      exp_ptr = exp_ptr + 16'd1;
    end
    repeat (4 * Q) @(negedge clk);
    chk(sda_pull == 1'b0, "R6", "SDA released after NACK", sda_pull, 0);
    chk(re_cnt - r0 == n, "R6", "read fetch count", re_cnt - r0, n);
    cond_stop();
  endtask

  initial begin
    logic       ack;
    logic [7:0] d;
    int         r0;
    logic [15:0] p;
    void'($urandom(32'd5150));
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    pull_prev = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R10", "reset pull", sda_pull, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R10", "reset strobes", {reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: wrong address is ignored until next start
    wlog.delete();
    r0 = re_cnt;
    cond_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R1", "foreign address not acked", ack, 0);
    send_byte(8'h12, ack);
    chk(!ack, "R1", "ignored byte not acked", ack, 0);
    send_byte(8'h00, ack);
    send_byte(8'hA5, ack);
    chk(!ack, "R1", "ignored data not acked", ack, 0);
    cond_stop();
    cond_start();
    send_byte({DEV ^ 7'h40, 1'b1}, ack);
    chk(!ack, "R1", "foreign read not acked", ack, 0);
    cond_stop();
    chk(wlog.size() == 0, "R1", "no write for foreign address", wlog.size(), 0);
    chk(re_cnt == r0, "R1", "no read for foreign address", re_cnt - r0, 0);

    // R3/R4: a plain burst, then the pointer wrap
    wr_txn(16'h1234, 5);
    wr_txn(16'hFFFE, 4);
    chk(exp_ptr == 16'h0002, "R4", "model wrap", exp_ptr, 2);

    // R5: read continues from pointer left by the wrapped write
    cond_start();
    rd_body(2);

    // R7/R5: pointer-only write, repeated start, read
    cond_start();
    wr_head(16'hABCD);
    cond_start();
    rd_body(3);

    // R8: partial data byte ended by a stop
    wlog.delete();
    cond_start();
    wr_head(16'h0400);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_bits(8'hF0, 5);
    cond_stop();
    chk(wlog.size() == 2, "R8", "stop drops partial byte", wlog.size(), 2);
    exp_ptr = 16'h0402;
    cond_start();
    rd_body(1);

    // R8/R7: partial byte ended by a repeated start
    wlog.delete();
    cond_start();
    wr_head(16'h0777);
    send_bits(8'hAA, 3);
    cond_start();
    rd_body(2);
    chk(wlog.size() == 0, "R8", "start drops partial byte", wlog.size(), 0);

    // Random bursts
    for (int it = 0; it < 12; it++) begin
      p = 16'($urandom);
      wr_txn(p, 1 + int'($urandom_range(0, 4)));
      p = 16'($urandom);
      wr_txn(p, 0);
      cond_start();
      rd_body(1 + int'($urandom_range(0, 4)));
    end

    chk(viol == 0, "R9", "SDA drive changed while SCL high", viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule